// File: doc/BRIEF.md
# TDM Audio Frame Transmitter

This block serializes the codec-to-controller frame of a time-division multiplexed audio link. The frame has 256 bit times: a 16-bit tag slot followed by twelve 20-bit slots. The controller marks a frame start by raising a sync line. On each rising bit-clock edge after that, the block drives one bit, most significant first, so the controller can sample it on the following falling edge.

During a frame the block collects what the next frame must carry. This includes at most one register-read response (an index and its 16-bit data) and the newest left and right capture samples. At the next frame start it freezes them into a 256-bit image and shifts that image out. The tag slot reports whether the codec is ready and which slots carry valid content. When the codec is not ready, the whole frame is sent as zeros and anything held for it is discarded.

Top module: `tdmtx_top`

## Requirements
- R1: The first bit of every frame (tag bit 15) equals the codec-ready input as sampled on the rising edge that starts the frame.
- R2: A read request accepted during one frame is answered in the following frame only. Slot 1 carries bit 19 = 0, the 7-bit index in bits 18:12 and zeros in bits 11:0. Slot 2 carries the 16-bit data in bits 19:4 and zeros in bits 3:0. Tag bits 14 and 13 are both set in that frame, and both are clear in later frames unless a new read arrives.
- R3: A write access (request with the read flag clear) has no effect: slots 1 and 2 are zero and tag bits 14 and 13 stay clear.
- R4: A left capture sample offered during one frame goes out in slot 3 of the next frame, and a right sample in slot 4. Each 18-bit sample fills bits 19:2 of its slot, MSB first, with bits 1:0 zero. Tag bit 12 marks slot 3 valid and tag bit 11 marks slot 4 valid.
- R5: A capture channel with no new sample during the previous frame sends an all-zero slot, and its tag bit is clear.
- R6: When codec-ready is low at frame start, all 256 bits of that frame are zero. Any pending read response or sample is dropped, so the next ready frame carries none of them.
- R7: A frame starts on the first rising edge at which sync is seen high after having been low. Bit Fn is driven after the n-th following rising edge. Sync held high does not restart the frame.
- R8: Tag bits 10:0 and slots 5 to 12 are always zero. Between the end of a frame's 256th bit and the next frame start, the serial output is zero.
- R9: A read request or sample presented on the same edge that starts a frame belongs to the frame after that one.
- R10: If several read requests arrive within one frame, the last one is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_sync | input | 1 | Frame marker from the controller; a rising level starts a frame |
| codec_ready | input | 1 | Codec ready flag, sent as the first tag bit |
| acc_vld | input | 1 | Register access strobe, one cycle |
| acc_rd | input | 1 | 1 = read access to be answered, 0 = write |
| acc_idx | input | 7 | Register index of the read |
| acc_data | input | 16 | Read data returned for that index |
| cap_l_vld | input | 1 | New left capture sample strobe |
| cap_l | input | 18 | Left capture sample |
| cap_r_vld | input | 1 | New right capture sample strobe |
| cap_r | input | 18 | Right capture sample |
| ser_out | output | 1 | Serial frame data toward the controller |

## Verification
The bench builds the block with its default parameters: 16-bit tag, twelve 20-bit slots, 18-bit samples, a 7-bit index and 16-bit read data, with left and right capture in slots 3 and 4. These values make the full 256-bit frame observable bit by bit. They also bring the slot-boundary padding into reach: the 12 zero bits after the index, the 4 after the read data and the 2 after each sample. With them, the bench covers edge cases at frame start, including a request arriving on the starting edge and sync held high across the whole frame.

// File: rtl/tdmtx_pkg.sv
`timescale 1ns/1ps
package tdmtx_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int IDX_W     = 7;
  localparam int RDATA_W   = 16;
  localparam int SAMP_W    = 18;

  typedef struct packed {
    logic               rd;
    logic [IDX_W-1:0]   idx;
    logic [RDATA_W-1:0] data;
  } rd_rsp_t;

  typedef struct packed {
    logic              vld;
    logic [SAMP_W-1:0] smp;
  } cap_t;
endpackage

// File: rtl/tdmtx_timing.sv
`timescale 1ns/1ps
module tdmtx_timing #(
  parameter int FRAME_W = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  output logic frame_start,
  output logic in_frame
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);

  logic             sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next state
  always_comb begin
    frame_start = frame_sync & ~sync_q;
    in_frame    = (cnt_q < CNT_END);
    cnt_en      = frame_start | in_frame;
    cnt_d       = cnt_q;
    if (frame_start)   cnt_d = '0;
    else if (in_frame) cnt_d = cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      cnt_q  <= CNT_END;
    end else begin
      sync_q <= frame_sync;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R7
  restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END);
endmodule

// File: rtl/tdmtx_pending.sv
`timescale 1ns/1ps
module tdmtx_pending
  import tdmtx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               acc_vld,
  input  logic               acc_rd,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic [RDATA_W-1:0] acc_data,
  input  logic               cap_l_vld,
  input  logic [SAMP_W-1:0]  cap_l,
  input  logic               cap_r_vld,
  input  logic [SAMP_W-1:0]  cap_r,
  output rd_rsp_t            rsp,
  output cap_t               left,
  output cap_t               right
);
  rd_rsp_t rsp_q, rsp_d;
  cap_t    left_q, left_d, right_q, right_d;
  logic    rsp_en, left_en, right_en;
  logic    rd_take;

  // next state: frame start consumes, a new strobe in the same cycle wins
  always_comb begin
    rd_take  = acc_vld & acc_rd;
    rsp_en   = frame_start | rd_take;
    left_en  = frame_start | cap_l_vld;
    right_en = frame_start | cap_r_vld;

    rsp_d = rsp_q;
    if (frame_start) rsp_d.rd = 1'b0;
    if (rd_take) begin
      rsp_d.rd   = 1'b1;
      rsp_d.idx  = acc_idx;
      rsp_d.data = acc_data;
    end

    left_d = left_q;
    if (frame_start) left_d.vld = 1'b0;
    if (cap_l_vld) begin
      left_d.vld = 1'b1;
      left_d.smp = cap_l;
    end

    right_d = right_q;
    if (frame_start) right_d.vld = 1'b0;
    if (cap_r_vld) begin
      right_d.vld = 1'b1;
      right_d.smp = cap_r;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      if (rsp_en)   rsp_q   <= rsp_d;
      if (left_en)  left_q  <= left_d;
      if (right_en) right_q <= right_d;
    end
  end

  assign rsp   = rsp_q;
  assign left  = left_q;
  assign right = right_q;

  // R9
  late_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && acc_vld && acc_rd) |=> rsp_q.rd);
endmodule

// File: rtl/tdmtx_assemble.sv
`timescale 1ns/1ps
module tdmtx_assemble
  import tdmtx_pkg::*;
#(
  parameter int L_SLOT = 3,
  parameter int R_SLOT = 4
) (
  input  logic               ready,
  input  rd_rsp_t            rsp,
  input  cap_t               left,
  input  cap_t               right,
  output logic [FRAME_W-1:0] frame
);
  localparam int PAY_W   = SLOT_W * NUM_SLOTS;
  localparam int IDX_PAD = SLOT_W - 1 - IDX_W;
  localparam int DAT_PAD = SLOT_W - RDATA_W;
  localparam int SMP_PAD = SLOT_W - SAMP_W;

  logic [TAG_W-1:0] tag;
  logic [PAY_W-1:0] payload;

  always_comb begin
    tag = '0;
    tag[TAG_W-1]      = ready;
    tag[TAG_W-2]      = rsp.rd;
    tag[TAG_W-3]      = rsp.rd;
    tag[TAG_W-1-L_SLOT] = left.vld;
    tag[TAG_W-1-R_SLOT] = right.vld;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int SNUM = s + 1;
    logic [SLOT_W-1:0] word;
    if (SNUM == 1) begin : g_echo
      assign word = rsp.rd ? {1'b0, rsp.idx, {IDX_PAD{1'b0}}} : '0;
    end else if (SNUM == 2) begin : g_rdata
      assign word = rsp.rd ? {rsp.data, {DAT_PAD{1'b0}}} : '0;
    end else if (SNUM == L_SLOT) begin : g_left
      assign word = left.vld ? {left.smp, {SMP_PAD{1'b0}}} : '0;
    end else if (SNUM == R_SLOT) begin : g_right
      assign word = right.vld ? {right.smp, {SMP_PAD{1'b0}}} : '0;
    end else begin : g_zero
      assign word = '0;
    end
    assign payload[(NUM_SLOTS-s)*SLOT_W-1 -: SLOT_W] = word;
  end

  assign frame = ready ? {tag, payload} : '0;
endmodule

// File: rtl/tdmtx_shift.sv
`timescale 1ns/1ps
module tdmtx_shift #(
  parameter int FRAME_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               in_frame,
  input  logic               ready,
  input  logic [FRAME_W-1:0] frame,
  output logic               frm_ready,
  output logic               ser_out
);
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               shreg_en;
  logic               rdy_q;

  // next state
  always_comb begin
    shreg_en = frame_start | in_frame;
    if (frame_start) shreg_d = frame;
    else             shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      if (shreg_en)    shreg_q <= shreg_d;
      if (frame_start) rdy_q   <= ready;
    end
  end

  assign ser_out   = in_frame & shreg_q[FRAME_W-1];
  assign frm_ready = rdy_q;
endmodule

// File: rtl/tdmtx_top.sv
`timescale 1ns/1ps
module tdmtx_top
  import tdmtx_pkg::*;
#(
  parameter int L_SLOT = 3,
  parameter int R_SLOT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_sync,
  input  logic        codec_ready,
  input  logic        acc_vld,
  input  logic        acc_rd,
  input  logic [6:0]  acc_idx,
  input  logic [15:0] acc_data,
  input  logic        cap_l_vld,
  input  logic [17:0] cap_l,
  input  logic        cap_r_vld,
  input  logic [17:0] cap_r,
  output logic        ser_out
);
  logic [1:0]         rst_q;
  logic               rst_n_s;
  logic               frame_start, in_frame, frm_ready;
  rd_rsp_t            rsp;
  cap_t               left, right;
  logic [FRAME_W-1:0] frame;

  // reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  tdmtx_timing #(.FRAME_W(FRAME_W)) i_timing (
    .clk(clk), .rst_n(rst_n_s), .frame_sync(frame_sync),
    .frame_start(frame_start), .in_frame(in_frame)
  );

  tdmtx_pending i_pending (
    .clk(clk), .rst_n(rst_n_s), .frame_start(frame_start),
    .acc_vld(acc_vld), .acc_rd(acc_rd), .acc_idx(acc_idx), .acc_data(acc_data),
    .cap_l_vld(cap_l_vld), .cap_l(cap_l), .cap_r_vld(cap_r_vld), .cap_r(cap_r),
    .rsp(rsp), .left(left), .right(right)
  );

  tdmtx_assemble #(.L_SLOT(L_SLOT), .R_SLOT(R_SLOT)) i_assemble (
    .ready(codec_ready), .rsp(rsp), .left(left), .right(right), .frame(frame)
  );

  tdmtx_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_n_s), .frame_start(frame_start), .in_frame(in_frame),
    .ready(codec_ready), .frame(frame), .frm_ready(frm_ready), .ser_out(ser_out)
  );

  // R1
  tag_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_start |=> (ser_out == $past(codec_ready)));

  // R6
  quiet_frame_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ser_out |-> frm_ready);
endmodule

// File: tb/test_tdmtx_top.sv
`timescale 1ns/1ps
module test_tdmtx_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_sync, codec_ready, acc_vld, acc_rd;
  logic [6:0]  acc_idx;
  logic [15:0] acc_data;
  logic        cap_l_vld, cap_r_vld;
  logic [17:0] cap_l, cap_r;
  logic        ser_out;
  int          total = 0;
  int          bad   = 0;

  always #2.5 clk = ~clk;

  tdmtx_top i_tdmtx_top (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .codec_ready(codec_ready),
    .acc_vld(acc_vld), .acc_rd(acc_rd), .acc_idx(acc_idx), .acc_data(acc_data),
    .cap_l_vld(cap_l_vld), .cap_l(cap_l), .cap_r_vld(cap_r_vld), .cap_r(cap_r),
    .ser_out(ser_out)
  );

  function automatic logic [255:0] exp_frame(input logic rdy, input logic rd,
      input logic [6:0] idx, input logic [15:0] dat, input logic lv,
      input logic [17:0] l, input logic rv, input logic [17:0] r);
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    tag = {rdy, rd, rd, lv, rv, 11'b0};
    s1  = rd ? {1'b0, idx, 12'b0} : 20'b0;
    s2  = rd ? {dat, 4'b0} : 20'b0;
    s3  = lv ? {l, 2'b0} : 20'b0;
    s4  = rv ? {r, 2'b0} : 20'b0;
    return rdy ? {tag, s1, s2, s3, s4, 160'b0} : 256'b0;
  endfunction

  task automatic chk_frame(input string req, input logic [255:0] got, input logic [255:0] exp);
    total += 2;
    if (got[255:240] !== exp[255:240]) begin
      bad++;
      $display("FAIL %s tag: got %h expected %h", req, got[255:240], exp[255:240]);
    end
    if (got[239:0] !== exp[239:0]) begin
      bad++;
      $display("FAIL %s slots: got %h expected %h", req, got[239:0], exp[239:0]);
    end
  endtask

  task automatic chk_quiet(input string req);
    logic seen = 1'b0;
    repeat (4) begin
      @(negedge clk);
      seen |= ser_out;
    end
    total++;
    if (seen !== 1'b0) begin
      bad++;
      $display("FAIL %s idle output: got %b expected 0", req, seen);
    end
  endtask

  // called at a negedge; strobes already set by the caller fall with sync
  task automatic run_frame(input bit hold, output logic [255:0] got);
    frame_sync = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i == 0) begin
        acc_vld = 1'b0; cap_l_vld = 1'b0; cap_r_vld = 1'b0;
        if (!hold) frame_sync = 1'b0;
      end
      got[255-i] = ser_out;
    end
    frame_sync = 1'b0;
  endtask

  task automatic pulse_acc(input logic rd, input logic [6:0] idx, input logic [15:0] dat);
    acc_vld = 1'b1; acc_rd = rd; acc_idx = idx; acc_data = dat;
    @(negedge clk);
    acc_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_cap(input logic lv, input logic [17:0] l, input logic rv, input logic [17:0] r);
    cap_l_vld = lv; cap_l = l; cap_r_vld = rv; cap_r = r;
    @(negedge clk);
    cap_l_vld = 1'b0; cap_r_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; frame_sync = 1'b0; codec_ready = 1'b1; acc_vld = 1'b0; acc_rd = 1'b0;
    acc_idx = '0; acc_data = '0; cap_l_vld = 1'b0; cap_r_vld = 1'b0; cap_l = '0; cap_r = '0;
    repeat (4) @(negedge clk);
    total++;
    if (ser_out !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset output: got %b expected 0", ser_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_quiet("R8 after reset");
  endtask

  task automatic t_idle;
    logic [255:0] got;
    run_frame(1'b0, got);
    chk_frame("R1 R8 empty ready frame", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0));
    chk_quiet("R8 after frame end");
  endtask

  task automatic t_read;
    logic [255:0] got;
    pulse_acc(1'b1, 7'h26, 16'hA5C3);
    run_frame(1'b0, got);
    chk_frame("R2 read echo", got, exp_frame(1, 1, 7'h26, 16'hA5C3, 0, 0, 0, 0));
    run_frame(1'b0, got);
    chk_frame("R2 echo once only", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_write;
    logic [255:0] got;
    pulse_acc(1'b0, 7'h18, 16'hFFFF);
    run_frame(1'b0, got);
    chk_frame("R3 write no echo", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_capture;
    logic [255:0] got;
    pulse_cap(1'b1, 18'h2ABCD, 1'b1, 18'h12345);
    run_frame(1'b0, got);
    chk_frame("R4 stereo capture", got, exp_frame(1, 0, 0, 0, 1, 18'h2ABCD, 1, 18'h12345));
    pulse_cap(1'b1, 18'h3FFFF, 1'b0, 18'h0);
    run_frame(1'b0, got);
    chk_frame("R5 left only", got, exp_frame(1, 0, 0, 0, 1, 18'h3FFFF, 0, 0));
    run_frame(1'b0, got);
    chk_frame("R5 no new samples", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_not_ready;
    logic [255:0] got;
    pulse_acc(1'b1, 7'h7E, 16'h1234);
    pulse_cap(1'b1, 18'h15555, 1'b1, 18'h2AAAA);
    codec_ready = 1'b0;
    run_frame(1'b0, got);
    chk_frame("R6 not ready frame", got, 256'b0);
    codec_ready = 1'b1;
    run_frame(1'b0, got);
    chk_frame("R6 pending dropped", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_same_edge;
    logic [255:0] got;
    acc_vld = 1'b1; acc_rd = 1'b1; acc_idx = 7'h02; acc_data = 16'h8001;
    cap_r_vld = 1'b1; cap_r = 18'h20001;
    run_frame(1'b0, got);
    chk_frame("R9 start-edge request deferred", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0));
    run_frame(1'b0, got);
    chk_frame("R9 deferred request sent", got, exp_frame(1, 1, 7'h02, 16'h8001, 0, 0, 1, 18'h20001));
  endtask

  task automatic t_overwrite;
    logic [255:0] got;
    pulse_acc(1'b1, 7'h10, 16'h1111);
    pulse_acc(1'b1, 7'h7C, 16'hBEEF);
    pulse_acc(1'b0, 7'h00, 16'h0000);
    run_frame(1'b0, got);
    chk_frame("R10 last read wins", got, exp_frame(1, 1, 7'h7C, 16'hBEEF, 0, 0, 0, 0));
  endtask

  task automatic t_sync_hold;
    logic [255:0] got;
    pulse_acc(1'b1, 7'h44, 16'h0F0F);
    run_frame(1'b1, got);
    chk_frame("R7 sync held high", got, exp_frame(1, 1, 7'h44, 16'h0F0F, 0, 0, 0, 0));
    chk_quiet("R7 no restart on held sync");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_read();
    t_write();
    t_capture();
    t_not_ready();
    t_same_edge();
    t_overwrite();
    t_sync_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule